// File: doc/BRIEF.md
# Receive-Path Destination Filter

This block sits on the byte stream between a link-layer receiver and the host. In the receive direction it reads the first byte of every frame, which carries the destination identifier. It then forwards or discards the whole frame. A frame is kept when that byte equals the local 8-bit node identifier, when it equals the all-ones broadcast value 0xFF, or when the pass-all input is high. Any other frame is swallowed in full, up to and including its last beat. A small buffer in the receive path holds the beats that are kept. Its depth defaults to one entry.

Both receive-side streams use valid/ready handshakes, and a beat moves on a clock edge where valid and ready are both high. The output side may hold ready low for any length of time. While it does, the block holds valid, data and last steady, and back-pressure reaches the input only for beats that are being kept. Beats that belong to a dropped frame are taken at once, whatever the output side is doing. The transmit-direction stream is a pure combinational wire-through: data, last and valid run downstream and ready runs upstream, with no storage and no change.

Top module: `stream_addr_filter`

## Requirements
- R1: After reset `rx_out_valid` is 0, and the first input beat after reset is treated as the header byte of a new frame.
- R2: A frame whose header byte equals `node_id` is forwarded whole, header included, with bytes and the last flag in input order.
- R3: A frame whose header byte matches neither `node_id` nor 0xFF, with `pass_all` low, produces no output beat at all, including its last beat.
- R4: A header byte of 0xFF is accepted as broadcast for any value of `node_id`.
- R5: While `pass_all` is 1 at the header beat, the frame is forwarded whatever its header byte.
- R6: The beat after a beat with `rx_in_last`=1 is a new header. A frame of a single beat (header with last=1) is filtered on its own.
- R7: During a dropped frame, `rx_in_ready` is 1 on every beat, even with `rx_out_ready` held at 0.
- R8: The keep/drop choice is fixed when the header beat is taken. Changing `node_id` or `pass_all` later in that frame does not alter it.
- R9: While `rx_out_valid`=1 and `rx_out_ready`=0, the output holds valid, data and last stable on the next cycle. No kept beat is lost or duplicated.
- R10: In the same cycle, `tx_out_data`, `tx_out_last` and `tx_out_valid` equal their `tx_in_*` counterparts, and `tx_in_ready` equals `tx_out_ready`.
- R11: With the output stalled, exactly DEPTH kept beats are accepted, and after that `rx_in_ready` is 0 for a kept frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 8 | Local destination identifier |
| pass_all | input | 1 | Forward every frame when high |
| rx_in_valid | input | 1 | Receive input beat valid |
| rx_in_ready | output | 1 | Receive input beat accepted |
| rx_in_data | input | 8 | Receive input byte |
| rx_in_last | input | 1 | Last beat of the frame |
| rx_out_valid | output | 1 | Filtered output beat valid |
| rx_out_ready | input | 1 | Downstream accepts the beat |
| rx_out_data | output | 8 | Filtered output byte |
| rx_out_last | output | 1 | Last beat of the forwarded frame |
| tx_in_valid | input | 1 | Transmit input beat valid |
| tx_in_ready | output | 1 | Transmit input accepted (copy of `tx_out_ready`) |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_last | input | 1 | Transmit input last flag |
| tx_out_valid | output | 1 | Transmit output beat valid |
| tx_out_ready | input | 1 | Transmit downstream ready |
| tx_out_data | output | 8 | Transmit output byte |
| tx_out_last | output | 1 | Transmit output last flag |

## Verification
The bench builds the block with the default buffer depth of one. A single stalled output cycle therefore fills the buffer and pushes back on the input. This brings the full-buffer limit, the hold-stable rule and the contrast with dropped frames (which never stall) within reach in only a few beats. Output readiness is randomised, and a scoreboard checks the order of kept bytes across mixed matching, foreign, broadcast, pass-all and single-beat frames, including frames whose identifier inputs change after the header.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;
  localparam int unsigned BYTE_W = 8;

  // Header test used for the keep/drop choice.
  function automatic logic header_hit(input logic [BYTE_W-1:0] hdr,
                                      input logic [BYTE_W-1:0] id,
                                      input logic              all);
    return all || (hdr == id) || (&hdr);
  endfunction
endpackage

// File: rtl/sfilt_decide.sv
module sfilt_decide
  import sfilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic [BYTE_W-1:0] node_id,
  input  logic              pass_all,
  input  logic              buf_ready,
  output logic              push
);
  logic at_header_q;
  logic keep_q;
  logic hit;
  logic keep_now;
  logic fire;

  assign hit      = header_hit(in_data, node_id, pass_all);
  assign keep_now = at_header_q ? hit : keep_q;
  assign in_ready = keep_now ? buf_ready : 1'b1;
  assign fire     = in_valid && in_ready;
  assign push     = fire && keep_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      at_header_q <= 1'b1;
      keep_q      <= 1'b0;
    end else if (fire) begin
      at_header_q <= in_last;
      if (at_header_q) keep_q <= hit;
    end
  end

  AST_FIRST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> at_header_q); // R6
  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_header_q) |=> $stable(keep_q)); // R8
  AST_DROP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !at_header_q && !keep_q) |-> (in_ready && !push)); // R7
endmodule

// File: rtl/sfilt_buf.sv
module sfilt_buf #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem_data [DEPTH];
  logic          mem_last [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign out_valid = (count != '0);
  assign in_ready  = (count != FULL_CNT) || out_ready;
  assign out_data  = mem_data[rd_ptr];
  assign out_last  = mem_last[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_data[wr_ptr] <= in_data;
      mem_last[wr_ptr] <= in_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
endmodule

// File: rtl/sfilt_txpass.sv
module sfilt_txpass #(
  parameter int unsigned W = 8
) (
  input  logic         a_valid,
  output logic         a_ready,
  input  logic [W-1:0] a_data,
  input  logic         a_last,
  output logic         b_valid,
  input  logic         b_ready,
  output logic [W-1:0] b_data,
  output logic         b_last
);
  assign b_valid = a_valid;
  assign b_data  = a_data;
  assign b_last  = a_last;
  assign a_ready = b_ready;
endmodule

// File: rtl/stream_addr_filter.sv
module stream_addr_filter
  import sfilt_pkg::*;
#(
  parameter int unsigned DEPTH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] node_id,
  input  logic              pass_all,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [BYTE_W-1:0] rx_in_data,
  input  logic              rx_in_last,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [BYTE_W-1:0] rx_out_data,
  output logic              rx_out_last,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [BYTE_W-1:0] tx_in_data,
  input  logic              tx_in_last,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_data,
  output logic              tx_out_last
);
  logic buf_ready;
  logic push;

  sfilt_decide u_decide (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready),
    .in_data(rx_in_data), .in_last(rx_in_last),
    .node_id(node_id), .pass_all(pass_all),
    .buf_ready(buf_ready), .push(push)
  );

  sfilt_buf #(.W(BYTE_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(push), .in_ready(buf_ready),
    .in_data(rx_in_data), .in_last(rx_in_last),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .out_data(rx_out_data), .out_last(rx_out_last)
  );

  sfilt_txpass #(.W(BYTE_W)) u_tx (
    .a_valid(tx_in_valid), .a_ready(tx_in_ready),
    .a_data(tx_in_data), .a_last(tx_in_last),
    .b_valid(tx_out_valid), .b_ready(tx_out_ready),
    .b_data(tx_out_data), .b_last(tx_out_last)
  );
endmodule

// File: tb/stream_addr_filter_tb.sv
module stream_addr_filter_tb;
  localparam int DEPTH = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] node_id = 8'h00;
  logic pass_all = 1'b0;
  logic rx_in_valid = 1'b0, rx_in_last = 1'b0;
  logic [7:0] rx_in_data = 8'h00;
  logic rx_in_ready;
  logic rx_out_valid, rx_out_last;
  logic [7:0] rx_out_data;
  logic rx_out_ready = 1'b0;
  logic tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_out_ready = 1'b0;
  logic [7:0] tx_in_data = 8'h00;
  logic tx_in_ready, tx_out_valid, tx_out_last;
  logic [7:0] tx_out_data;

  int total = 0, bad = 0, cycles = 0;
  bit hold_out = 1'b1;
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;

  stream_addr_filter #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .pass_all(pass_all),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(rx_in_data), .rx_in_last(rx_in_last),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_data(rx_out_data), .rx_out_last(rx_out_last),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_in_last(tx_in_last),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data), .tx_out_last(tx_out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: random output readiness, stability and scoreboard pops.
  initial begin
    bit stalled = 1'b0;
    logic [8:0] held = '0;
    forever begin
      @(negedge clk);
      rx_out_ready = hold_out ? 1'b0 : ($urandom_range(0, 3) != 0);
      #2;
      if (rst_n && stalled)
        check(rx_out_valid && {rx_out_last, rx_out_data} == held, "R9 hold",
              {rx_out_valid, rx_out_last, rx_out_data}, {1'b1, held});
      if (rst_n && rx_out_valid && rx_out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R3 unexpected beat", {rx_out_last, rx_out_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({rx_out_last, rx_out_data} == e, "R2 order", {rx_out_last, rx_out_data}, e);
        end
      end
      stalled = rst_n && rx_out_valid && !rx_out_ready;
      held = {rx_out_last, rx_out_data};
    end
  end

  task automatic send_frame(input logic [7:0] b[$], input logic [7:0] id, input bit all,
                            input bit mid_change, input bit chk_ready, input string req);
    bit keep;
    @(negedge clk);
    node_id = id;
    pass_all = all;
    keep = all || (b[0] == id) || (b[0] == 8'hFF);
    for (int i = 0; i < b.size(); i++)
      if (keep) exp_q.push_back({(i == b.size() - 1), b[i]});
    for (int i = 0; i < b.size(); i++) begin
      if (i != 0) @(negedge clk);
      rx_in_valid = 1'b1;
      rx_in_data = b[i];
      rx_in_last = (i == b.size() - 1);
      if (i == 1 && mid_change) begin
        node_id = keep ? ~id : b[0];
        pass_all = !keep;
      end
      #2;
      if (chk_ready) check(rx_in_ready, req, rx_in_ready, 1);
      while (!rx_in_ready) begin
        @(negedge clk);
        #2;
      end
      @(posedge clk);
    end
    @(negedge clk);
    rx_in_valid = 1'b0;
    rx_in_last = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(rx_out_valid == 1'b0, "R1 reset valid", rx_out_valid, 0);

    // R10: transmit wire-through, same cycle
    tx_in_valid = 1'b1; tx_in_data = 8'hA5; tx_in_last = 1'b1; tx_out_ready = 1'b0;
    #1;
    check(tx_out_valid && tx_out_data == 8'hA5 && tx_out_last, "R10 fwd",
          {tx_out_valid, tx_out_last, tx_out_data}, 10'h3A5);
    check(tx_in_ready == 1'b0, "R10 ready low", tx_in_ready, 0);
    tx_out_ready = 1'b1; tx_in_data = 8'h3C; tx_in_last = 1'b0;
    #1;
    check(tx_in_ready && tx_out_data == 8'h3C && !tx_out_last, "R10 ready high",
          {tx_in_ready, tx_out_last, tx_out_data}, 10'h23C);
    tx_in_valid = 1'b0;

    // R7: dropped frame with output stalled; every beat taken immediately
    hold_out = 1'b1;
    send_frame('{8'h21, 8'h01, 8'h02, 8'h03}, 8'h10, 1'b0, 1'b0, 1'b1, "R7 drop ready");
    #2;
    check(rx_out_valid == 1'b0, "R3 nothing out", rx_out_valid, 0);

    // R11: stalled output, kept frame fills DEPTH entries then back-pressures
    @(negedge clk);
    node_id = 8'h10;
    exp_q.push_back({1'b0, 8'h10});
    exp_q.push_back({1'b1, 8'h55});
    rx_in_valid = 1'b1; rx_in_data = 8'h10; rx_in_last = 1'b0;
    #2;
    check(rx_in_ready, "R11 first slot", rx_in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    rx_in_data = 8'h55; rx_in_last = 1'b1;
    #2;
    check(rx_in_ready == 1'b0, "R11 full", rx_in_ready, 0);
    hold_out = 1'b0;
    while (!rx_in_ready) begin @(negedge clk); #2; end
    @(posedge clk);
    @(negedge clk);
    rx_in_valid = 1'b0; rx_in_last = 1'b0;

    // Mixed traffic under random output readiness
    send_frame('{8'h10, 8'hAA, 8'hBB}, 8'h10, 1'b0, 1'b0, 1'b0, "R2");
    send_frame('{8'h11, 8'hCC}, 8'h10, 1'b0, 1'b0, 1'b0, "R3");
    send_frame('{8'hFF, 8'h01, 8'h02}, 8'h10, 1'b0, 1'b0, 1'b0, "R4");
    send_frame('{8'h42, 8'h99, 8'h98}, 8'h10, 1'b1, 1'b0, 1'b0, "R5");
    send_frame('{8'h10}, 8'h10, 1'b0, 1'b0, 1'b0, "R6 single keep");
    send_frame('{8'h33}, 8'h10, 1'b0, 1'b0, 1'b0, "R6 single drop");
    send_frame('{8'h10}, 8'h10, 1'b0, 1'b0, 1'b0, "R6 single keep");
    send_frame('{8'h10, 8'h01, 8'h02, 8'h03}, 8'h10, 1'b0, 1'b1, 1'b0, "R8 keep held");
    send_frame('{8'h07, 8'h07, 8'h07}, 8'h10, 1'b0, 1'b1, 1'b0, "R8 drop held");
    for (int k = 0; k < 20; k++) begin
      logic [7:0] fr[$];
      int len;
      len = $urandom_range(1, 5);
      for (int j = 0; j < len; j++) fr.push_back(8'($urandom_range(0, 255)));
      if (k % 3 == 0) fr[0] = 8'h10;
      send_frame(fr, 8'h10, (k % 7 == 6), 1'b0, 1'b0, "R2 R3 mix");
    end

    // Drain and confirm nothing is owed or extra
    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(posedge clk);
    repeat (5) @(posedge clk);
    check(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
    #1;
    check(rx_out_valid == 1'b0, "R3 no leftover", rx_out_valid, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule